// File: doc/BRIEF.md
# Parallel ATA PIO Cycle Engine

This block converts single host register accesses into programmed-I/O cycles on a parallel ATA drive bus. A host raises a request with a direction, a four-bit drive register select and, for writes, the data. It holds the request until it sees a one-clock acknowledge. Each bus cycle has three phases: address setup, an active strobe on the read or write line, and recovery. The length of each phase comes from a bank of byte-wide timing registers, and the drive's ready line may stretch the active phase.

A control byte holds three bits. One is an active-low bus reset, which also holds the engine in its idle state. One lets the drive's ready line take effect. The third marks a pending DMA transfer, and while it is set an active DMA burst keeps new PIO cycles off the bus. The idle status output lets software find a quiet moment to change the timing settings. A host access made while the bus is held in reset is acknowledged at once and has no effect.

Top module: `ata_pio_engine`

## Requirements
- R1: After chip reset the control byte reads 0, `ata_rst_n` is low, `controller_idle` is high, both strobes are high, `ata_cs_n` is 2'b11, and every timing register reads 1.
- R2: Bit 6 of the control byte drives `ata_rst_n`. Clearing it during a cycle ends that cycle: `controller_idle` is high and both strobes are high one clock after `ata_rst_n` falls.
- R3: While bit 6 is 0, a host request is acknowledged on the next clock and no bus cycle starts. A discarded read returns 0. The engine acts on the value of bit 6 before a control write in the same clock takes effect.
- R4: A cycle holds `controller_idle` low for S+A+R clocks, with the strobe low for A of them. S, A and R are timing registers 0, 1 and 2, and a value of 0 counts as 1.
- R5: A write is acknowledged in the first clock of its setup phase, before the bus cycle ends. `ata_dout` carries the write data while `ata_diow_n` is low.
- R6: A read drives `ata_dior_n` low during the active phase. The value on `ata_din` in the last active clock is returned on `host_rdata`, with the acknowledge given in the first recovery clock.
- R7: With bit 5 set, a low `ata_iordy` at the end of the active phase holds the strobe low until the line returns high. With bit 5 clear, `ata_iordy` has no effect on cycle length.
- R8: Timing registers are sampled when a cycle starts. A timing write during a cycle changes only later cycles.
- R9: `ata_da` equals `host_addr[2:0]`. `host_addr[3]`=0 drives `ata_cs_n`=2'b10 and `host_addr[3]`=1 drives 2'b01. `ata_da`, `ata_cs_n` and `ata_dout` hold steady for the whole cycle.
- R10: While control bit 7 and `dma_burst` are both high, no PIO cycle starts. The pending request starts in the clock after either one drops.
- R11: All 24 timing registers can be written and read back on `tim_rdata`. An index of 24 or more reads 0 and ignores writes.
- R12: The two strobes are never low at the same time, and each acknowledge lasts one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Chip reset, active low |
| ctrl_we | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte value: bit 7 DMA pending, bit 6 bus reset release, bit 5 ready enable |
| ctrl_q | output | 8 | Current control byte |
| tim_we | input | 1 | Timing register write strobe |
| tim_addr | input | 5 | Timing register index |
| tim_wdata | input | 8 | Timing register write value |
| tim_rdata | output | 8 | Timing register at `tim_addr` |
| host_req | input | 1 | Host access request, held until acknowledged |
| host_we | input | 1 | 1 for write, 0 for read |
| host_addr | input | 4 | Drive register select: bit 3 chip select, bits 2:0 address |
| host_wdata | input | 16 | Host write data |
| host_ack | output | 1 | One-clock access acknowledge |
| host_rdata | output | 16 | Read data, valid with `host_ack` |
| dma_burst | input | 1 | A DMA burst currently owns the bus |
| controller_idle | output | 1 | High when no bus cycle is in progress |
| ata_rst_n | output | 1 | Drive bus reset, active low |
| ata_cs_n | output | 2 | Drive chip selects, active low |
| ata_da | output | 3 | Drive register address |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| ata_dout | output | 16 | Data driven toward the drive |
| ata_dout_en | output | 1 | Output enable for `ata_dout` |
| ata_din | input | 16 | Data from the drive |
| ata_iordy | input | 1 | Drive ready line |

## Verification
Two events can land on the same clock edge: a control write that changes bit 6, and a host request. The bench raises both on the same clock in each direction. With a write that clears bit 6, the request must still be accepted and acknowledged under the old setting, but the cycle must end one clock later without either strobe falling. With a write that sets bit 6 while the bus is in reset, the request must be acknowledged as discarded, and `controller_idle` must never drop.

// File: rtl/ata_pio_engine.sv
module ata_pio_engine #(
  parameter int DW   = 16,
  parameter int TW   = 8,
  parameter int NTIM = 24,
  localparam int TAW = $clog2(NTIM)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ctrl_we,
  input  logic [7:0]     ctrl_wdata,
  output logic [7:0]     ctrl_q,
  input  logic           tim_we,
  input  logic [TAW-1:0] tim_addr,
  input  logic [TW-1:0]  tim_wdata,
  output logic [TW-1:0]  tim_rdata,
  input  logic           host_req,
  input  logic           host_we,
  input  logic [3:0]     host_addr,
  input  logic [DW-1:0]  host_wdata,
  output logic           host_ack,
  output logic [DW-1:0]  host_rdata,
  input  logic           dma_burst,
  output logic           controller_idle,
  output logic           ata_rst_n,
  output logic [1:0]     ata_cs_n,
  output logic [2:0]     ata_da,
  output logic           ata_dior_n,
  output logic           ata_diow_n,
  output logic [DW-1:0]  ata_dout,
  output logic           ata_dout_en,
  input  logic [DW-1:0]  ata_din,
  input  logic           ata_iordy
);
  localparam int BIT_DMA = 7;
  localparam int BIT_RST = 6;
  localparam int BIT_RDY = 5;
  localparam logic [TW-1:0]  ONE  = TW'(1);
  localparam logic [TAW-1:0] LAST = TAW'(NTIM - 1);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_ACT, S_REC} st_t;

  st_t            st;
  logic [TW-1:0]  cnt, act_len, rec_len;
  logic [TW-1:0]  tim [NTIM];
  logic           we_q;
  logic [1:0]     cs_q;
  logic [2:0]     da_q;
  logic [DW-1:0]  dout_q;

  function automatic logic [TW-1:0] at_least_one(input logic [TW-1:0] v);
    return (v == '0) ? ONE : v;
  endfunction

  wire bus_on   = ctrl_q[BIT_RST];
  wire rdy_en   = ctrl_q[BIT_RDY];
  wire dma_hold = ctrl_q[BIT_DMA] && dma_burst;
  wire fresh    = host_req && !host_ack;
  wire go       = (st == S_IDLE) && fresh && !dma_hold;
  wire act_end  = (cnt == '0) && (!rdy_en || ata_iordy);

  assign ata_rst_n       = bus_on;
  assign controller_idle = (st == S_IDLE);
  assign ata_dior_n      = !((st == S_ACT) && !we_q);
  assign ata_diow_n      = !((st == S_ACT) && we_q);
  assign ata_dout_en     = (st != S_IDLE) && we_q;
  assign ata_cs_n        = (st == S_IDLE) ? 2'b11 : cs_q;
  assign ata_da          = da_q;
  assign ata_dout        = dout_q;
  assign tim_rdata       = (tim_addr <= LAST) ? tim[tim_addr] : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NTIM; i++) tim[i] <= ONE;
    end else if (tim_we && tim_addr <= LAST) begin
      tim[tim_addr] <= tim_wdata;
    end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; act_len <= ONE; rec_len <= ONE;
      we_q <= 1'b0; cs_q <= 2'b11; da_q <= '0; dout_q <= '0;
      host_ack <= 1'b0; host_rdata <= '0;
    end else begin
      host_ack <= 1'b0;
      if (!bus_on) begin
        st <= S_IDLE;
        if (fresh) begin
          host_ack   <= 1'b1;
          host_rdata <= '0;
        end
      end else begin
        case (st)
          S_IDLE: if (go) begin
            st      <= S_SETUP;
            cnt     <= at_least_one(tim[0]) - ONE;
            act_len <= at_least_one(tim[1]);
            rec_len <= at_least_one(tim[2]);
            we_q    <= host_we;
            cs_q    <= host_addr[3] ? 2'b01 : 2'b10;
            da_q    <= host_addr[2:0];
            dout_q  <= host_wdata;
            if (host_we) host_ack <= 1'b1;
          end
          S_SETUP:
            if (cnt == '0) begin st <= S_ACT; cnt <= act_len - ONE; end
            else cnt <= cnt - ONE;
          S_ACT:
            if (cnt != '0) cnt <= cnt - ONE;
            else if (act_end) begin
              st  <= S_REC;
              cnt <= rec_len - ONE;
              if (!we_q) begin host_ack <= 1'b1; host_rdata <= ata_din; end
            end
          S_REC:
            if (cnt == '0) st <= S_IDLE;
            else cnt <= cnt - ONE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  a_r12_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ata_dior_n && !ata_diow_n));
  a_r12_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |=> !host_ack);
  a_r2_reset_quiets: assert property (@(posedge clk) disable iff (!rst_n)
    !ata_rst_n |=> (controller_idle && ata_dior_n && ata_diow_n));
  a_r9_bus_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!controller_idle && !$past(controller_idle)) |->
      ($stable(ata_da) && $stable(ata_cs_n) && $stable(ata_dout)));
  a_r7_iordy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACT && cnt == '0 && rdy_en && !ata_iordy && bus_on) |=> (st == S_ACT));
  a_r10_dma_block: assert property (@(posedge clk) disable iff (!rst_n)
    (controller_idle && dma_hold) |=> controller_idle);
endmodule

// File: tb/ata_pio_engine_test.sv
module ata_pio_engine_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic ctrl_we = 0, tim_we = 0, host_req = 0, host_we = 0, dma_burst = 0, ata_iordy = 1;
  logic [7:0] ctrl_wdata = 0, tim_wdata = 0;
  logic [4:0] tim_addr = 0;
  logic [3:0] host_addr = 0;
  logic [15:0] host_wdata = 0, ata_din = 0;
  logic [7:0] ctrl_q, tim_rdata;
  logic host_ack, controller_idle, ata_rst_n, ata_dior_n, ata_diow_n, ata_dout_en;
  logic [15:0] host_rdata, ata_dout;
  logic [1:0] ata_cs_n;
  logic [2:0] ata_da;

  ata_pio_engine uut (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int len1(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic int strobe_len(input int a, input int w, input bit en);
    int l = len1(a);
    if (en && w + 1 > l) l = w + 1;
    return l;
  endfunction

  function automatic logic [1:0] cs_of(input logic [3:0] a);
    return a[3] ? 2'b01 : 2'b10;
  endfunction

  task automatic wr_ctrl(input logic [7:0] v);
    @(negedge clk); ctrl_we = 1; ctrl_wdata = v;
    @(negedge clk); ctrl_we = 0;
  endtask

  task automatic wr_tim(input int a, input int v);
    @(negedge clk); tim_we = 1; tim_addr = 5'(a); tim_wdata = 8'(v);
    @(negedge clk); tim_we = 0;
  endtask

  task automatic access(input bit we, input logic [3:0] a, input logic [15:0] wd,
                        input int w, input bit midw,
                        output int busy, output int strb, output int acks,
                        output int ackpos, output logic [15:0] rd,
                        output bit dout_ok, output bit bus_ok);
    bit seen = 0;
    @(negedge clk);
    host_req = 1; host_we = we; host_addr = a; host_wdata = wd; ata_iordy = 1;
    busy = 0; strb = 0; acks = 0; ackpos = -1; rd = '0; dout_ok = 1; bus_ok = 1;
    for (int n = 0; n < 80; n++) begin
      @(negedge clk);
      tim_we = 0;
      if (!controller_idle) begin busy++; seen = 1; end
      if (host_ack) begin acks++; ackpos = busy; rd = host_rdata; host_req = 0; end
      if (!ata_dior_n || !ata_diow_n) begin
        strb++;
        if (we && (ata_dout !== wd || !ata_dout_en)) dout_ok = 0;
        ata_iordy = !(strb <= w);
      end else ata_iordy = 1;
      if (!controller_idle && (ata_da !== a[2:0] || ata_cs_n !== cs_of(a))) bus_ok = 0;
      if (midw && busy == 1) begin tim_we = 1; tim_addr = 5'd1; tim_wdata = 8'd9; end
      if (seen && controller_idle) break;
      if (!seen && acks > 0 && n > 4) break;
    end
    host_req = 0; tim_we = 0; ata_iordy = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int busy, strb, acks, ackpos;
    logic [15:0] rd;
    bit dok, bok;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ctrl", ctrl_q, 0);
    chk("R1 bus reset", ata_rst_n, 0);
    chk("R1 idle", controller_idle, 1);
    chk("R1 strobes", {ata_dior_n, ata_diow_n}, 2'b11);
    chk("R1 cs", ata_cs_n, 2'b11);
    tim_addr = 0; #1 chk("R1 timing default", tim_rdata, 1);

    // R3: accesses while bus held in reset
    access(0, 4'h3, 16'h0, 0, 0, busy, strb, acks, ackpos, rd, dok, bok);
    chk("R3 read acked", acks, 1);
    chk("R3 no cycle", busy, 0);
    chk("R3 no strobe", strb, 0);
    chk("R3 read zero", rd, 0);
    access(1, 4'h5, 16'hBEEF, 0, 0, busy, strb, acks, ackpos, rd, dok, bok);
    chk("R3 write acked", acks, 1);
    chk("R3 write no cycle", busy, 0);

    // R11: timing bank readback and range
    wr_tim(23, 8'hA5);
    tim_addr = 23; #1 chk("R11 top reg", tim_rdata, 8'hA5);
    wr_tim(24, 8'h77);
    tim_addr = 24; #1 chk("R11 out of range", tim_rdata, 0);
    wr_tim(12, 8'h3C);
    tim_addr = 12; #1 chk("R11 middle reg", tim_rdata, 8'h3C);

    wr_ctrl(8'h40);
    chk("R2 release", ata_rst_n, 1);

    // R4/R5/R9 directed write
    wr_tim(0, 2); wr_tim(1, 3); wr_tim(2, 2);
    access(1, 4'hA, 16'h1234, 0, 0, busy, strb, acks, ackpos, rd, dok, bok);
    chk("R4 busy", busy, 7);
    chk("R4 strobe", strb, 3);
    chk("R5 ack early", ackpos, 1);
    chk("R5 dout", dok, 1);
    chk("R9 addr cs", bok, 1);

    // R4 zero timing counts as one; R6 read
    wr_tim(0, 0); wr_tim(1, 0); wr_tim(2, 0);
    ata_din = 16'hC0DE;
    access(0, 4'h2, 16'h0, 0, 0, busy, strb, acks, ackpos, rd, dok, bok);
    chk("R4 zero busy", busy, 3);
    chk("R6 rdata", rd, 16'hC0DE);
    chk("R6 ack at recovery", ackpos, 3);

    // R7 ignored when disabled
    wr_tim(0, 1); wr_tim(1, 2); wr_tim(2, 1);
    access(0, 4'h1, 16'h0, 5, 0, busy, strb, acks, ackpos, rd, dok, bok);
    chk("R7 ignored strobe", strb, 2);
    wr_ctrl(8'h60);
    access(0, 4'h1, 16'h0, 5, 0, busy, strb, acks, ackpos, rd, dok, bok);
    chk("R7 stretched strobe", strb, 6);
    chk("R7 stretched busy", busy, 8);

    // R8 timing write during a cycle
    access(1, 4'h4, 16'h55AA, 0, 1, busy, strb, acks, ackpos, rd, dok, bok);
    chk("R8 running cycle", strb, 2);
    access(1, 4'h4, 16'h55AA, 0, 0, busy, strb, acks, ackpos, rd, dok, bok);
    chk("R8 next cycle", strb, 9);
    wr_tim(1, 2);

    // R10 DMA ownership
    wr_ctrl(8'hE0);
    dma_burst = 1;
    @(negedge clk); host_req = 1; host_we = 0; host_addr = 4'h7;
    repeat (6) @(negedge clk);
    chk("R10 blocked idle", controller_idle, 1);
    chk("R10 no ack", host_ack, 0);
    dma_burst = 0;
    @(negedge clk);
    chk("R10 starts", controller_idle, 0);
    for (int n = 0; n < 20 && !host_ack; n++) @(negedge clk);
    host_req = 0;
    for (int n = 0; n < 20 && !controller_idle; n++) @(negedge clk);
    wr_ctrl(8'h60);

    // R2 abort during a cycle
    wr_tim(0, 3); wr_tim(1, 5); wr_tim(2, 3);
    @(negedge clk); host_req = 1; host_we = 1; host_addr = 4'h0;
    @(negedge clk); host_req = 0; ctrl_we = 1; ctrl_wdata = 8'h20;
    @(negedge clk); ctrl_we = 0;
    chk("R2 bus reset asserted", ata_rst_n, 0);
    @(negedge clk);
    chk("R2 abort idle", controller_idle, 1);
    chk("R2 abort strobes", {ata_dior_n, ata_diow_n}, 2'b11);

    // R3 same-clock: request with control write that sets bit 6
    @(negedge clk); host_req = 1; host_we = 1; ctrl_we = 1; ctrl_wdata = 8'h40;
    @(negedge clk); ctrl_we = 0;
    chk("R3 same clock ack", host_ack, 1);
    chk("R3 same clock idle", controller_idle, 1);
    host_req = 0;
    @(negedge clk);
    chk("R3 same clock still idle", controller_idle, 1);

    // R3 same-clock: request with control write that clears bit 6
    @(negedge clk); host_req = 1; host_we = 1; ctrl_we = 1; ctrl_wdata = 8'h00;
    @(negedge clk); ctrl_we = 0; host_req = 0;
    chk("R3 old bit accepts", host_ack, 1);
    chk("R3 old bit starts", controller_idle, 0);
    @(negedge clk);
    chk("R2 aborted at once", controller_idle, 1);
    chk("R2 strobe never fell", ata_diow_n, 1);

    // random mix R4..R9
    for (int k = 0; k < 40; k++) begin
      int s = $urandom_range(0, 5), a = $urandom_range(0, 5), r = $urandom_range(0, 5);
      int w = $urandom_range(0, 6);
      bit en = 1'($urandom_range(0, 1)), we = 1'($urandom_range(0, 1));
      logic [3:0] ad = 4'($urandom);
      logic [15:0] wd = 16'($urandom);
      ata_din = 16'($urandom);
      wr_ctrl(en ? 8'h60 : 8'h40);
      wr_tim(0, s); wr_tim(1, a); wr_tim(2, r);
      access(we, ad, wd, w, 0, busy, strb, acks, ackpos, rd, dok, bok);
      chk("R7 random strobe", strb, strobe_len(a, w, en));
      chk("R4 random busy", busy, len1(s) + strobe_len(a, w, en) + len1(r));
      chk("R9 random bus", bok, 1);
      if (we) chk("R5 random dout", dok, 1);
      else chk("R6 random rdata", rd, ata_din);
      chk("R6 random ack pos", ackpos, we ? 1 : len1(s) + strobe_len(a, w, en) + 1);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule